// File: doc/BRIEF.md
# Converter Serial Configuration Interface

This block is the digital control front end of a multichannel converter. After each conversion finishes it holds the block in a data-output state. There, on every rising serial-clock edge with chip select low, it presents the 24-bit result MSB first on the serial output and collects a 13-bit configuration word from the serial input. The word is a 3-bit command prefix, a 5-bit channel address and a 5-bit speed field.

A rising edge on chip select during the data-output state ends the transfer and starts the next conversion. At that moment the new settings are applied, provided the prefix requested an update and all 13 bits were received. The block drives the positive and negative input selects, a 4-bit oversampling code and a double-rate flag to the converter. A done strobe and a 24-bit result input stand in for the analog modulator and the filter.

Serial clock, chip select and serial data are treated as signals synchronous to the block clock. Edges are found by comparing each sample with the one before it.

Top module: `cfg_serial_if`

## Requirements
- R1: After reset the block is converting (busy = 1), the positive select is 0, the negative select is 1, the oversampling code is 4'b0001, twox = 0, illegal_cmd = 0 and sdo = 0.
- R2: conv_done while busy clears busy on the next cycle. With cs_n low in the data-output state, sdo carries result bit 23 first, and each serial-clock rising edge advances sdo to the next lower bit. sdo is 0 in every other case.
- R3: Serial-clock edges while busy, or while cs_n is high, shift nothing: neither sdo nor the captured command changes.
- R4: A cs_n rising edge in the data-output state sets busy on the next cycle and pulses conv_start for exactly one cycle. A cs_n rising edge while busy has no effect.
- R5: The word is received MSB first: bits 12..10 are the prefix, bits 9..5 are the address {SGL, ODD, A2, A1, A0}, and bits 4..0 are the speed field {OSR[3:0], TWOX}. With prefix 3'b101 and all 13 bits received, the address and speed are applied at conversion start.
- R6: Prefixes 3'b000 and 3'b100 leave the channel and speed unchanged.
- R7: With prefix 3'b101, a speed field of 5'b00000 keeps the previous oversampling code and twox, while the address still updates.
- R8: A transfer ended by cs_n before 13 bits have arrived leaves the configuration unchanged.
- R9: The positive select is 2*A0+ODD. With SGL = 1 the negative select is 4 (the common input). With SGL = 0 it is 2*A0+(1-ODD). A2 and A1 have no effect.
- R10: Any other prefix updates nothing and sets illegal_cmd when the third bit arrives. The flag stays set until reset.
- R11: The channel selects, oversampling code and twox change only in the cycle in which conv_start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; a rising edge starts a conversion |
| sck | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial configuration input |
| conv_done | input | 1 | Conversion finished strobe |
| result | input | 24 | Conversion result to shift out |
| sdo | output | 1 | Serial result output |
| busy | output | 1 | High while converting |
| conv_start | output | 1 | One-cycle pulse when a new conversion begins |
| chan_pos | output | 3 | Positive input select (0..3) |
| chan_neg | output | 3 | Negative input select (0..3, or 4 for common) |
| osr_code | output | 4 | Active oversampling code |
| twox | output | 1 | Active double-rate mode |
| illegal_cmd | output | 1 | Sticky flag for an undefined prefix |

## Verification
The assertions assume that conv_done arrives only while the converter is busy. They also assume that sck and cs_n are held for at least one clock between changes, so that every level is sampled. The stimulus keeps sck, cs_n and sdi changing on the falling clock edge only, and holds each level for a full clock period. It raises conv_done only while busy, and toggles chip select during conversion only in the test that shows it is ignored. Expected selects are computed from the address bits, and the expected configuration is carried forward by a model of the commit rules.

// File: rtl/cfg_serial_pkg.sv
// Package: shared constants and types for the serial configuration interface.
// Assumes the command word layout prefix | address | speed, received MSB first.
package cfg_serial_pkg;
    localparam int PFX_W  = 3;
    localparam int ADDR_W = 5;
    localparam int SPD_W  = 5;
    localparam int CMD_W  = PFX_W + ADDR_W + SPD_W;
    localparam int CNT_W  = $clog2(CMD_W + 1);
    localparam int SEL_W  = 3;

    localparam logic [PFX_W-1:0]  PFX_UPDATE = 3'b101;
    localparam logic [PFX_W-1:0]  PFX_HOLD_A = 3'b000;
    localparam logic [PFX_W-1:0]  PFX_HOLD_B = 3'b100;
    localparam logic [ADDR_W-1:0] ADDR_RESET = 5'b00000;
    localparam logic [SPD_W-1:0]  SPD_RESET  = 5'b00010;
    localparam logic [SEL_W-1:0]  SEL_COMMON = 3'd4;

    typedef enum logic {PH_CONVERT = 1'b0, PH_OUTPUT = 1'b1} phase_t;

    function automatic logic prefix_known(input logic [PFX_W-1:0] p);
        return (p == PFX_UPDATE) || (p == PFX_HOLD_A) || (p == PFX_HOLD_B);
    endfunction
endpackage

// File: rtl/cfg_rise_detect.sv
// Module: rising-edge detector for a level already synchronous to clk.
// Assumes each level is held for at least one clk period.
module cfg_rise_detect #(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= RST_LEVEL;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/cfg_cmd_shift.sv
// Module: collects up to CMD_W command bits MSB first and counts them.
// Assumes clr is held during conversion, so every transfer starts empty.
module cfg_cmd_shift
    import cfg_serial_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             sdi,
    output logic [CMD_W-1:0] word,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    assign full = (count == CNT_W'(CMD_W));

    // Shift in one bit per enabled edge until the word is complete.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word  <= '0;
            count <= '0;
        end else if (shift_en && !full) begin
            word  <= {word[CMD_W-2:0], sdi};
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_chan_decode.sv
// Module: maps the stored channel address to positive and negative selects.
// Assumes address order {SGL, ODD, A2, A1, A0}; A2 and A1 are ignored.
module cfg_chan_decode
    import cfg_serial_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [SEL_W-1:0]  pos_sel,
    output logic [SEL_W-1:0]  neg_sel
);
    logic sgl, odd, a0;
    logic unused_addr_bits;

    assign sgl = addr[4];
    assign odd = addr[3];
    assign a0  = addr[0];
    assign unused_addr_bits = ^addr[2:1];

    // Select the pair member, or the common input for single-ended use.
    always_comb begin
        pos_sel = {1'b0, a0, odd};
        neg_sel = sgl ? SEL_COMMON : {1'b0, a0, ~odd};
    end
endmodule

// File: rtl/cfg_serial_if.sv
// Module: serial configuration front end of a multichannel converter.
// Shifts out the result and collects a command word during the output phase.
// Applies the command when chip select rises. Assumes synchronous inputs.
module cfg_serial_if
    import cfg_serial_pkg::*;
#(
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic             conv_done,
    input  logic [RES_W-1:0] result,
    output logic             sdo,
    output logic             busy,
    output logic             conv_start,
    output logic [SEL_W-1:0] chan_pos,
    output logic [SEL_W-1:0] chan_neg,
    output logic [SPD_W-2:0] osr_code,
    output logic             twox,
    output logic             illegal_cmd
);
    phase_t            phase_q;
    logic              sck_rise, cs_rise, shift_en, finish_xfer;
    logic [CMD_W-1:0]  cmd_word;
    logic [CNT_W-1:0]  cmd_count;
    logic              cmd_full;
    logic [PFX_W-1:0]  cmd_pfx;
    logic [ADDR_W-1:0] cmd_addr, addr_q;
    logic [SPD_W-1:0]  cmd_spd, spd_q;
    logic [RES_W-1:0]  out_sr;

    cfg_rise_detect #(.RST_LEVEL(1'b0)) i_sck_edge (
        .clk(clk), .rst_n(rst_n), .level(sck), .rise(sck_rise));
    cfg_rise_detect #(.RST_LEVEL(1'b1)) i_cs_edge (
        .clk(clk), .rst_n(rst_n), .level(cs_n), .rise(cs_rise));

    assign shift_en    = (phase_q == PH_OUTPUT) && !cs_n && sck_rise;
    assign finish_xfer = (phase_q == PH_OUTPUT) && cs_rise;

    cfg_cmd_shift i_cmd (
        .clk(clk), .rst_n(rst_n), .clr(phase_q == PH_CONVERT),
        .shift_en(shift_en), .sdi(sdi),
        .word(cmd_word), .count(cmd_count), .full(cmd_full));

    assign cmd_pfx  = cmd_word[CMD_W-1 -: PFX_W];
    assign cmd_addr = cmd_word[SPD_W +: ADDR_W];
    assign cmd_spd  = cmd_word[SPD_W-1:0];

    // Phase sequencing and the one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_CONVERT;
            conv_start <= 1'b0;
        end else begin
            conv_start <= finish_xfer;
            if (phase_q == PH_CONVERT && conv_done) phase_q <= PH_OUTPUT;
            else if (finish_xfer)                   phase_q <= PH_CONVERT;
        end
    end

    // Result shift register: loaded at conversion end, shifted per bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  out_sr <= '0;
        else if (phase_q == PH_CONVERT && conv_done) out_sr <= result;
        else if (shift_en)                           out_sr <= {out_sr[RES_W-2:0], 1'b0};
    end

    // Commit a complete update command when the next conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= ADDR_RESET;
            spd_q  <= SPD_RESET;
        end else if (finish_xfer && cmd_full && cmd_pfx == PFX_UPDATE) begin
            addr_q <= cmd_addr;
            if (cmd_spd != '0) spd_q <= cmd_spd;
        end
    end

    // Sticky flag for an undefined prefix, raised as its third bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_cmd <= 1'b0;
        else if (shift_en && cmd_count == CNT_W'(PFX_W - 1)
                 && !prefix_known({cmd_word[PFX_W-2:0], sdi}))
            illegal_cmd <= 1'b1;
    end

    cfg_chan_decode i_dec (.addr(addr_q), .pos_sel(chan_pos), .neg_sel(chan_neg));

    assign osr_code = spd_q[SPD_W-1:1];
    assign twox     = spd_q[0];
    assign busy     = (phase_q == PH_CONVERT);
    assign sdo      = (phase_q == PH_OUTPUT) && !cs_n && out_sr[RES_W-1];
endmodule

// File: rtl/cfg_serial_if_chk.sv
// Module: property checker for cfg_serial_if, attached by bind.
// Assumes conv_done is raised only while the block is busy.
module cfg_serial_if_chk
    import cfg_serial_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             conv_done,
    input logic             sdo,
    input logic             busy,
    input logic             conv_start,
    input logic [SEL_W-1:0] chan_pos,
    input logic [SEL_W-1:0] chan_neg,
    input logic [SPD_W-2:0] osr_code,
    input logic             twox,
    input logic             illegal_cmd
);
    AST_DONE_LEAVES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && conv_done |=> !busy); // R2
    AST_SDO_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sdo); // R2
    AST_START_FROM_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (busy && !$past(busy))); // R4
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4
    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_neg != SEL_COMMON) |-> (chan_pos[2:1] == chan_neg[2:1] && chan_pos[0] != chan_neg[0])); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |=> illegal_cmd); // R10
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable({chan_pos, chan_neg, osr_code, twox})); // R11
endmodule

bind cfg_serial_if cfg_serial_if_chk i_chk (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .sdo(sdo), .busy(busy),
    .conv_start(conv_start), .chan_pos(chan_pos), .chan_neg(chan_neg),
    .osr_code(osr_code), .twox(twox), .illegal_cmd(illegal_cmd));

// File: tb/test_cfg_serial_if.sv
// Bench: sweeps every address and speed value, then every prefix, aborts and ignored edges.
module test_cfg_serial_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, conv_done = 1'b0;
    logic [23:0] result = '0;
    logic        sdo, busy, conv_start, twox, illegal_cmd;
    logic [2:0]  chan_pos, chan_neg;
    logic [3:0]  osr_code;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [4:0] e_addr = 5'b00000, e_spd = 5'b00010;
    logic       e_ill = 1'b0;

    cfg_serial_if i_cfg_serial_if (.*);

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_cfg(input string req);
        chk(req, chan_pos, {1'b0, e_addr[0], e_addr[3]});
        chk(req, chan_neg, e_addr[4] ? 3'd4 : {1'b0, e_addr[0], ~e_addr[3]});
        chk(req, osr_code, e_spd[4:1]);
        chk(req, twox, e_spd[0]);
    endtask

    task automatic pulse_sck(input logic b);
        @(negedge clk) sdi = b;
        @(negedge clk) sck = 1'b1;
        @(negedge clk) sck = 1'b0;
    endtask

    task automatic finish_conv(input logic [23:0] res);
        @(negedge clk) begin result = res; conv_done = 1'b1; end
        @(negedge clk) conv_done = 1'b0;
        chk("R2 busy clears", busy, 1'b0);
    endtask

    // One full readout and command transfer, then conversion start and model update.
    task automatic run_txn(input logic [12:0] w, input int nbits, input logic [23:0] res, input string req);
        finish_conv(res);
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            chk("R2 sdo bit", sdo, res[23-i]);
            pulse_sck(i < 13 ? w[12-i] : 1'b0);
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk("R4 start pulse", conv_start, 1'b1);
        chk("R4 busy", busy, 1'b1);
        if (nbits >= 3 && !(w[12:10] == 3'b101 || w[12:10] == 3'b000 || w[12:10] == 3'b100))
            e_ill = 1'b1;
        if (nbits >= 13 && w[12:10] == 3'b101) begin
            e_addr = w[9:5];
            if (w[4:0] != 5'b0) e_spd = w[4:0];
        end
        chk_cfg(req);
        chk("R10 flag", illegal_cmd, e_ill);
        @(negedge clk);
        chk("R4 pulse width", conv_start, 1'b0);
        chk_cfg("R11 held");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 1'b1);
        chk("R1 sdo", sdo, 1'b0);
        chk("R1 flag", illegal_cmd, 1'b0);
        chk("R1 osr", osr_code, 4'b0001);
        chk_cfg("R1 defaults");

        // R2 full 24-bit readout with a hold command
        run_txn({3'b000, 5'b11111, 5'b11111}, 24, 24'hA5C3_96, "R6 hold");

        // R5 R7 R9 sweep of every address and speed value
        for (int a = 0; a < 32; a++)
            for (int s = 0; s < 32; s++)
                run_txn({3'b101, 5'(a), 5'(s)}, 13, 24'(a * 32 + s + 24'h5A0000), "R5 R7 R9 sweep");

        // R6 R10 every prefix with a payload that differs from the current setting
        for (int p = 0; p < 8; p++) begin
            run_txn({3'b101, 5'b01001, 5'b00110}, 13, 24'h0F0F0F, "R5 setup");
            run_txn({3'(p), 5'b10000, 5'b11011}, 13, 24'hF0F0F0, "R6 R10 prefix");
        end

        // R8 aborted transfers keep the configuration
        run_txn({3'b101, 5'b11110, 5'b01011}, 12, 24'h123456, "R8 abort 12");
        run_txn({3'b101, 5'b11110, 5'b01011}, 0, 24'h654321, "R8 abort 0");

        // R3 sck ignored with cs_n high in the output phase
        finish_conv(24'h800001);
        for (int i = 0; i < 13; i++) pulse_sck(1'b1);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk("R3 sdo not shifted", sdo, 1'b1);
        pulse_sck(1'b0);
        @(negedge clk);
        chk("R3 sdo after one edge", sdo, 1'b0);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk("R4 start", conv_start, 1'b1);
        chk_cfg("R3 R8 unchanged");

        // R3 R4 sck and chip-select edges while busy do nothing
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < 13; i++) begin
            pulse_sck(1'b1);
            chk("R3 sdo busy", sdo, 1'b0);
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk("R4 no start while busy", conv_start, 1'b0);
        @(negedge clk);
        chk("R4 still busy", busy, 1'b1);
        chk_cfg("R3 R11 unchanged");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule